// File: doc/BRIEF.md
# Sense-Data TDM Slave Transmitter

This block serialises three measurement words (load current, output voltage and supply level) onto a shared time-division-multiplexed line that is timed entirely by an external master. The bit clock is the block's only clock. A one-bit-wide frame sync pulse marks each frame. After reset the block counts bit clocks between two frame starts to learn how many 64-bit groups the bus carries, and it stays silent until that count is legal. From then on it drives only the 64 bit times of the group picked by `grp_sel`. Every other bit time is left to the other talkers, so up to four such transmitters can share one line.

The serial pin is modelled as a data bit `sdo` plus an enable `sdo_oe`, and the pad buffer sits outside the block. The data changes on falling bit-clock edges so that a receiver can capture it on rising edges. New measurement words are offered with a one-cycle strobe. The block copies them as one set at each frame start, so all three words in a frame come from the same sample.

Top module: `sense_tdm_tx`

## Requirements
- R1: While `rst_n` is low, and after release until the first driven frame, `sdo_oe` and `sdo` are both 0.
- R2: A frame starts at the rising edge of `bclk` that sees `fsync` high after it was low. Bit time j of the frame (j=0 at that edge) is put on the pin at the next falling edge and is valid at the following rising edge. Bit time 0 of a driven group 0 carries the current word's MSB.
- R3: The block locks when two consecutive frame starts are 64, 128, 192 or 256 bit clocks apart. The frame beginning at the second of these starts is the first one driven.
- R4: Before lock `sdo_oe` stays 0. Any other spacing keeps the block measuring, and the latest frame start becomes the new reference.
- R5: `grp_sel` is captured at the first frame start after reset. Later changes have no effect on which bit times are driven.
- R6: Value g of `grp_sel` selects bit times 64g to 64g+63 of the frame. Its slots 0, 1 and 2 (16 bit times each) carry the current word, the voltage word and the supply slot, each MSB first. Both 16-bit words are sent unaltered as two's complement.
- R7: The supply slot sends the 8-bit unsigned supply value MSB first, followed by 8 zero bits.
- R8: `sdo_oe` is 0 during slot 3 of the selected group and during every bit time of the other groups.
- R9: A frame sends the words held after the last `smp_stb` pulse that came before its start. A pulse inside a frame only affects later frames.
- R10: Whenever `sdo_oe` is 0, `sdo` is 0.
- R11: A group whose bit times lie beyond the locked frame length is never driven. This includes bit times that run past the frame end when a frame sync is late.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock from the bus master |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, one bit clock wide, changes on falling edges |
| grp_sel | input | 2 | Group assignment, sampled at first frame start |
| smp_stb | input | 1 | Strobe that loads the three measurement inputs |
| cur_in | input | 16 | Load current word, signed fraction |
| vlt_in | input | 16 | Output voltage word, signed fraction |
| sup_in | input | 8 | Supply level, unsigned |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Serial pin drive enable |

## Verification
The value of bit time j is driven at the falling edge that follows the rising edge on which the frame counter takes value j. That rising edge is the one after the falling edge where the bench presents fsync for bit j, so the result is due at the second rising edge after that stimulus. The driver stamps each expected enable/data pair with that due cycle and pushes it into a queue. The monitor pops entries 1 ns after each rising edge and reports any entry it reaches too late. Lock and strobe effects are predicted frame by frame from the spacing of earlier frame starts, so frames that are not driven are checked too, along with bit times past the frame end.

// File: rtl/sense_tdm_pkg.sv
package sense_tdm_pkg;

   // Frame tracking phases after reset.
   typedef enum logic [1:0] {
      TRK_IDLE = 2'd0,   // no frame start seen yet
      TRK_MEAS = 2'd1,   // counting bit clocks up to the next frame start
      TRK_LOCK = 2'd2    // legal frame length found, transmitting
   } trk_state_e;

endpackage

// File: rtl/sense_tdm_frame_trk.sv
module sense_tdm_frame_trk
   import sense_tdm_pkg::*;
#(
   parameter int GRP_BITS = 64,
   parameter int NUM_GRP  = 4,
   parameter int POS_W    = 9,
   parameter int GSEL_W   = 2,
   parameter int OFF_LG   = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fsync,
   input  logic [GSEL_W-1:0]       grp_sel,
   output logic                    fs_rise,
   output logic [POS_W-1:0]        pos,
   output logic                    locked,
   output logic [GSEL_W-1:0]       grp_q,
   output logic [POS_W-OFF_LG:0]   ngrp_q
);

   localparam int LEN_W = POS_W + 1;

   logic              fs_d;
   logic [POS_W-1:0]  pos_q;
   logic [LEN_W-1:0]  meas_len;
   logic [NUM_GRP-1:0] len_hit;
   logic              len_ok;
   trk_state_e        st_q;

   assign fs_rise  = fsync & ~fs_d;
   assign meas_len = LEN_W'(pos_q) + LEN_W'(1);

   // One comparator per legal frame length (1..NUM_GRP groups).
   for (genvar k = 0; k < NUM_GRP; k++) begin : g_len
      assign len_hit[k] = (meas_len == LEN_W'((k + 1) * GRP_BITS));
   end
   assign len_ok = |len_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_d   <= 1'b0;
         pos_q  <= '0;
         st_q   <= TRK_IDLE;
         grp_q  <= '0;
         ngrp_q <= '0;
      end else begin
         fs_d <= fsync;
         // Bit position within the frame, saturating so an overlong
         // frame can never alias onto a legal length.
         if (fs_rise) begin
            pos_q <= '0;
         end else if (pos_q != '1) begin
            pos_q <= pos_q + 1'b1;
         end
         if (fs_rise) begin
            case (st_q)
               TRK_IDLE: begin
                  st_q  <= TRK_MEAS;
                  grp_q <= grp_sel;
               end
               TRK_MEAS: begin
                  if (len_ok) begin
                     st_q   <= TRK_LOCK;
                     ngrp_q <= meas_len[POS_W:OFF_LG];
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign pos    = pos_q;
   assign locked = (st_q == TRK_LOCK);

   // R2: a frame start restarts the bit position.
   p_pos_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fs_rise |=> (pos_q == '0));

   // R3: once locked the block stays locked.
   p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R5: the group assignment never moves after it was captured.
   p_grp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q != TRK_IDLE) && $past(st_q != TRK_IDLE)) |-> $stable(grp_q));

endmodule

// File: rtl/sense_tdm_sample_hold.sv
module sense_tdm_sample_hold #(
   parameter int WORD_W = 16,
   parameter int SUP_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb,
   input  logic [WORD_W-1:0] cur_in,
   input  logic [WORD_W-1:0] vlt_in,
   input  logic [SUP_W-1:0]  sup_in,
   input  logic              load,
   output logic [WORD_W-1:0] cur_f,
   output logic [WORD_W-1:0] vlt_f,
   output logic [SUP_W-1:0]  sup_f
);

   logic [WORD_W-1:0] cur_s;
   logic [WORD_W-1:0] vlt_s;
   logic [SUP_W-1:0]  sup_s;

   // Staging set: follows the sample strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_s <= '0;
         vlt_s <= '0;
         sup_s <= '0;
      end else if (smp_stb) begin
         cur_s <= cur_in;
         vlt_s <= vlt_in;
         sup_s <= sup_in;
      end
   end

   // Frame set: copied once per frame start, read by the serializer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_f <= '0;
         vlt_f <= '0;
         sup_f <= '0;
      end else if (load) begin
         cur_f <= cur_s;
         vlt_f <= vlt_s;
         sup_f <= sup_s;
      end
   end

   // R9: words on the line stay fixed between frame starts.
   p_frame_coherent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(cur_f) && $stable(vlt_f) && $stable(sup_f)));

endmodule

// File: rtl/sense_tdm_serializer.sv
module sense_tdm_serializer #(
   parameter int WORD_W        = 16,
   parameter int SUP_W         = 8,
   parameter int SLOTS_PER_GRP = 4,
   parameter int POS_W         = 9,
   parameter int GSEL_W        = 2,
   parameter int OFF_LG        = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [POS_W-1:0]      pos,
   input  logic                  locked,
   input  logic [GSEL_W-1:0]     grp_q,
   input  logic [POS_W-OFF_LG:0] ngrp_q,
   input  logic [WORD_W-1:0]     cur_f,
   input  logic [WORD_W-1:0]     vlt_f,
   input  logic [SUP_W-1:0]      sup_f,
   output logic                  sdo,
   output logic                  sdo_oe
);

   localparam int BIT_LG  = $clog2(WORD_W);
   localparam int SLOT_LG = $clog2(SLOTS_PER_GRP);
   localparam int GHI_W   = POS_W - OFF_LG;

   logic [BIT_LG-1:0]  bit_idx;
   logic [BIT_LG-1:0]  tx_idx;
   logic [SLOT_LG-1:0] slot_idx;
   logic [GHI_W-1:0]   grp_hi;
   logic [WORD_W-1:0]  sup_pad;
   logic [WORD_W-1:0]  slot_word;
   logic               slot_live;
   logic               grp_mine;
   logic               grp_inside;
   logic               drive;
   logic               sdo_q;
   logic               oe_q;

   assign bit_idx  = pos[BIT_LG-1:0];
   assign slot_idx = pos[OFF_LG-1:BIT_LG];
   assign grp_hi   = pos[POS_W-1:OFF_LG];
   assign tx_idx   = ~bit_idx;   // MSB first; WORD_W is a power of two

   // Supply value sits in the top bits of its slot, the rest are zero.
   if (WORD_W > SUP_W) begin : g_sup_pad
      assign sup_pad = {sup_f, {(WORD_W - SUP_W){1'b0}}};
   end else begin : g_sup_full
      assign sup_pad = sup_f;
   end

   always_comb begin
      slot_word = '0;
      slot_live = 1'b0;
      case (slot_idx)
         SLOT_LG'(0): begin slot_word = cur_f;   slot_live = 1'b1; end
         SLOT_LG'(1): begin slot_word = vlt_f;   slot_live = 1'b1; end
         SLOT_LG'(2): begin slot_word = sup_pad; slot_live = 1'b1; end
         default:     begin slot_word = '0;      slot_live = 1'b0; end
      endcase
   end

   assign grp_mine   = (grp_hi == {1'b0, grp_q});
   assign grp_inside = ({1'b0, grp_hi} < ngrp_q);
   assign drive      = locked & grp_mine & grp_inside & slot_live;

   // Launch on the falling edge so the receiver samples on the rising one.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q  <= drive;
         sdo_q <= drive & slot_word[tx_idx];
      end
   end

   assign sdo    = sdo_q;
   assign sdo_oe = oe_q;

   // R4: nothing is driven before lock.
   p_quiet_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> !sdo_oe);

   // R10: a released line carries a zero data bit.
   p_released_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo);

   // R8: the fourth slot and foreign groups are never driven.
   p_spare_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (slot_idx < SLOT_LG'(3)));
   p_own_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (grp_hi == {1'b0, grp_q}));

   // R11: drive stays inside the locked frame length.
   p_inside_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> ({1'b0, grp_hi} < ngrp_q));

   // R7: padding bits of the supply slot are zero.
   p_pad_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && (slot_idx == SLOT_LG'(2)) && (int'(bit_idx) >= SUP_W)) |-> !sdo);

endmodule

// File: rtl/sense_tdm_tx.sv
module sense_tdm_tx #(
   parameter int WORD_W        = 16,
   parameter int SUP_W         = 8,
   parameter int SLOTS_PER_GRP = 4,
   parameter int NUM_GRP       = 4
) (
   input  logic        bclk,
   input  logic        rst_n,
   input  logic        fsync,
   input  logic [1:0]  grp_sel,
   input  logic        smp_stb,
   input  logic [15:0] cur_in,
   input  logic [15:0] vlt_in,
   input  logic [7:0]  sup_in,
   output logic        sdo,
   output logic        sdo_oe
);

   localparam int GRP_BITS  = WORD_W * SLOTS_PER_GRP;
   localparam int MAX_FRAME = GRP_BITS * NUM_GRP;
   localparam int GSEL_W    = $clog2(NUM_GRP);
   localparam int OFF_LG    = $clog2(GRP_BITS);
   localparam int POS_W     = $clog2(MAX_FRAME) + 1;

   // Elaboration-time parameter checks.
   if (WORD_W != 16 || SUP_W != 8 || NUM_GRP != 4) begin : g_chk_ports
      $error("sense_tdm_tx: port widths fix WORD_W=16, SUP_W=8, NUM_GRP=4");
   end
   if ((SLOTS_PER_GRP < 4) || ((SLOTS_PER_GRP & (SLOTS_PER_GRP - 1)) != 0)) begin : g_chk_slots
      $error("sense_tdm_tx: SLOTS_PER_GRP must be a power of two, at least 4");
   end
   if ((WORD_W & (WORD_W - 1)) != 0) begin : g_chk_word
      $error("sense_tdm_tx: WORD_W must be a power of two");
   end
   if ((SUP_W < 1) || (SUP_W > WORD_W)) begin : g_chk_sup
      $error("sense_tdm_tx: SUP_W must lie in 1..WORD_W");
   end

   logic                  fs_rise;
   logic [POS_W-1:0]      pos;
   logic                  locked;
   logic [GSEL_W-1:0]     grp_q;
   logic [POS_W-OFF_LG:0] ngrp_q;
   logic [WORD_W-1:0]     cur_f;
   logic [WORD_W-1:0]     vlt_f;
   logic [SUP_W-1:0]      sup_f;

   sense_tdm_frame_trk #(
      .GRP_BITS (GRP_BITS),
      .NUM_GRP  (NUM_GRP),
      .POS_W    (POS_W),
      .GSEL_W   (GSEL_W),
      .OFF_LG   (OFF_LG)
   ) u_trk (
      .clk     (bclk),
      .rst_n   (rst_n),
      .fsync   (fsync),
      .grp_sel (grp_sel),
      .fs_rise (fs_rise),
      .pos     (pos),
      .locked  (locked),
      .grp_q   (grp_q),
      .ngrp_q  (ngrp_q)
   );

   sense_tdm_sample_hold #(
      .WORD_W (WORD_W),
      .SUP_W  (SUP_W)
   ) u_hold (
      .clk     (bclk),
      .rst_n   (rst_n),
      .smp_stb (smp_stb),
      .cur_in  (cur_in),
      .vlt_in  (vlt_in),
      .sup_in  (sup_in),
      .load    (fs_rise),
      .cur_f   (cur_f),
      .vlt_f   (vlt_f),
      .sup_f   (sup_f)
   );

   sense_tdm_serializer #(
      .WORD_W        (WORD_W),
      .SUP_W         (SUP_W),
      .SLOTS_PER_GRP (SLOTS_PER_GRP),
      .POS_W         (POS_W),
      .GSEL_W        (GSEL_W),
      .OFF_LG        (OFF_LG)
   ) u_ser (
      .clk    (bclk),
      .rst_n  (rst_n),
      .pos    (pos),
      .locked (locked),
      .grp_q  (grp_q),
      .ngrp_q (ngrp_q),
      .cur_f  (cur_f),
      .vlt_f  (vlt_f),
      .sup_f  (sup_f),
      .sdo    (sdo),
      .sdo_oe (sdo_oe)
   );

endmodule

// File: tb/sense_tdm_tx_tb_top.sv
`timescale 1ns/1ps
module sense_tdm_tx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        fsync;
   logic [1:0]  grp_sel;
   logic        smp_stb;
   logic [15:0] cur_in;
   logic [15:0] vlt_in;
   logic [7:0]  sup_in;
   logic        sdo;
   logic        sdo_oe;

   always #2.5 clk = ~clk;   // 200 MHz bit clock

   sense_tdm_tx dut_i (
      .bclk    (clk),
      .rst_n   (rst_n),
      .fsync   (fsync),
      .grp_sel (grp_sel),
      .smp_stb (smp_stb),
      .cur_in  (cur_in),
      .vlt_in  (vlt_in),
      .sup_in  (sup_in),
      .sdo     (sdo),
      .sdo_oe  (sdo_oe)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0;
   int bad   = 0;

   // Scoreboard queues (parallel).
   int    q_due[$];
   bit    q_oe[$];
   bit    q_d[$];
   string q_tag[$];

   // Reference model state.
   int          m_phase;
   int          m_prev_len;
   int          m_grp;
   int          m_ngrp;
   logic [15:0] m_sc, m_sv, m_fc, m_fv;
   logic [7:0]  m_ss, m_fs;

   function automatic void check(string tag, bit act_oe, bit act_d, bit exp_oe, bit exp_d);
      total++;
      if (act_oe !== exp_oe || act_d !== exp_d) begin
         bad++;
         $display("FAIL %s: actual oe=%0b sdo=%0b expected oe=%0b sdo=%0b at cycle %0d",
                  tag, act_oe, act_d, exp_oe, exp_d, cyc);
      end
   endfunction

   function automatic void push_exp(int due, bit eo, bit ed, string tag);
      q_due.push_back(due);
      q_oe.push_back(eo);
      q_d.push_back(ed);
      q_tag.push_back(tag);
   endfunction

   // Monitor: compares each expected pair at its due rising edge.
   always @(posedge clk) begin
      #1;
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
         int    due;
         bit    eo, ed;
         string tg;
         due = q_due.pop_front();
         eo  = q_oe.pop_front();
         ed  = q_d.pop_front();
         tg  = q_tag.pop_front();
         if (due < cyc) begin
            total++;
            bad++;
            $display("FAIL %s: actual late at cycle %0d expected due cycle %0d", tg, cyc, due);
         end else begin
            check(tg, sdo_oe, sdo, eo, ed);
         end
      end
   end

   function automatic bit legal_len(int l);
      return (l == 64) || (l == 128) || (l == 192) || (l == 256);
   endfunction

   // Expected pin state for bit time j of a frame (R2, R6, R7, R8, R11).
   function automatic void exp_bit(int j, bit drive, string tag,
                                   output bit eo, output bit ed, output string et);
      int g = j / 64;
      int o = j % 64;
      int s = o / 16;
      int b = o % 16;
      eo = 1'b0;
      ed = 1'b0;
      et = tag;
      if (!drive) begin
         if (et == "") et = "R4";
      end else if (g != m_grp || m_grp >= m_ngrp) begin
         if (et == "") et = (m_grp >= m_ngrp) ? "R11" : "R8";
      end else if (s == 3) begin
         if (et == "") et = "R8";
      end else begin
         eo = 1'b1;
         case (s)
            0:       ed = m_fc[15 - b];
            1:       ed = m_fv[15 - b];
            default: ed = (b < 8) ? m_fs[7 - b] : 1'b0;
         endcase
         if (et == "") et = (s == 2) ? "R7" : ((s == 0 && b == 0) ? "R2" : "R6");
      end
   endfunction

   task automatic do_reset(logic [1:0] g);
      @(negedge clk);
      rst_n   = 1'b0;
      fsync   = 1'b0;
      smp_stb = 1'b0;
      grp_sel = g;
      cur_in  = '0;
      vlt_in  = '0;
      sup_in  = '0;
      m_phase = 0; m_prev_len = 0; m_grp = 0; m_ngrp = 0;
      m_sc = '0; m_sv = '0; m_ss = '0; m_fc = '0; m_fv = '0; m_fs = '0;
      repeat (3) @(negedge clk);
      #1;
      check("R1 in reset", sdo_oe, sdo, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1 after release", sdo_oe, sdo, 1'b0, 1'b0);
   endtask

   task automatic stb_only(logic [15:0] c, logic [15:0] v, logic [7:0] s);
      @(negedge clk);
      cur_in = c; vlt_in = v; sup_in = s; smp_stb = 1'b1;
      @(negedge clk);
      smp_stb = 1'b0;
      m_sc = c; m_sv = v; m_ss = s;
   endtask

   task automatic run_frame(int len, int stb_at, logic [15:0] nc, logic [15:0] nv,
                            logic [7:0] ns, string tag);
      bit drive;
      if (m_phase == 0) begin
         m_phase = 1;
         m_grp   = int'(grp_sel);
      end else if (m_phase == 1 && legal_len(m_prev_len)) begin
         m_phase = 2;
         m_ngrp  = m_prev_len / 64;
      end
      drive = (m_phase == 2);
      m_fc = m_sc; m_fv = m_sv; m_fs = m_ss;   // R9: set copied at frame start
      for (int j = 0; j < len; j++) begin
         bit    eo, ed;
         string et;
         @(negedge clk);
         fsync   = (j == 0);
         smp_stb = (j == stb_at);
         if (j == stb_at) begin
            cur_in = nc; vlt_in = nv; sup_in = ns;
         end
         exp_bit(j, drive, tag, eo, ed, et);
         push_exp(cyc + 2, eo, ed, et);
      end
      if (stb_at >= 0) begin
         m_sc = nc; m_sv = nv; m_ss = ns;
      end
      m_prev_len = len;
   endtask

   task automatic run_tail(int n, string tag);
      for (int t = 0; t < n; t++) begin
         @(negedge clk);
         fsync   = 1'b0;
         smp_stb = 1'b0;
         push_exp(cyc + 2, 1'b0, 1'b0, tag);
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic run_all();
      // 64-bit frames, group 0, plus mid-frame strobe (R3, R6, R7, R9)
      do_reset(2'd0);
      stb_only(16'h8001, 16'h7FFE, 8'hA5);
      run_frame(64, -1, '0, '0, '0, "R3");
      run_frame(64, -1, '0, '0, '0, "");
      run_frame(64, 20, 16'h1234, 16'hC3A9, 8'h5A, "R9");
      run_frame(64, -1, '0, '0, '0, "R9");
      run_tail(20, "R8");

      // 128-bit frames, group 1, group select changed after lock (R5)
      do_reset(2'd1);
      stb_only(16'hF00F, 16'h0FF0, 8'h81);
      run_frame(128, -1, '0, '0, '0, "R3");
      run_frame(128, -1, '0, '0, '0, "");
      grp_sel = 2'd0;
      run_frame(128, 90, 16'h0001, 16'hFFFF, 8'hFF, "R5");
      run_frame(128, -1, '0, '0, '0, "R5");
      run_tail(20, "R8");

      // 256-bit frames, last group
      do_reset(2'd3);
      stb_only(16'hAAAA, 16'h5555, 8'h3C);
      run_frame(256, -1, '0, '0, '0, "R3");
      run_frame(256, -1, '0, '0, '0, "");
      run_tail(20, "R8");

      // 192-bit frames, group 2
      do_reset(2'd2);
      stb_only(16'h6B2D, 16'h9410, 8'h01);
      run_frame(192, -1, '0, '0, '0, "R3");
      run_frame(192, 100, 16'h7FFF, 16'h8000, 8'h80, "");
      run_frame(192, -1, '0, '0, '0, "R9");
      run_tail(20, "R8");

      // Group beyond a 64-bit frame: never driven, also past frame end (R11)
      do_reset(2'd2);
      stb_only(16'hFFFF, 16'hFFFF, 8'hFF);
      run_frame(64, -1, '0, '0, '0, "R3");
      run_frame(64, -1, '0, '0, '0, "R11");
      run_frame(64, -1, '0, '0, '0, "R11");
      run_tail(160, "R11");

      // Illegal spacings keep measuring, then lock on 64 (R4)
      do_reset(2'd0);
      stb_only(16'hBEEF, 16'h0BAD, 8'hC7);
      run_frame(100, -1, '0, '0, '0, "R4");
      run_frame(70, -1, '0, '0, '0, "R4");
      run_frame(64, -1, '0, '0, '0, "R4");
      run_frame(64, -1, '0, '0, '0, "");
      run_tail(20, "R10");
   endtask

   initial begin
      rst_n   = 1'b0;
      fsync   = 1'b0;
      smp_stb = 1'b0;
      grp_sel = 2'd0;
      cur_in  = '0;
      vlt_in  = '0;
      sup_in  = '0;
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule